// File: doc/BRIEF.md
# Programmable Tick Timer

This block produces periodic ticks at a software-selected fraction of a 60 Hz base rate and drives a peripheral interrupt request on each tick. The host gives it commands through a single strobed command port carrying three 16-bit words. The word on `reg_a` picks the operation and `reg_b` carries its argument. Results come back on `reg_c`. A prescaler divides the system clock by `CLK_PER_BASE` to make the 60 Hz base pulse.

A period command loads a divisor B, so that one tick spans B base periods, which gives 60/B ticks per second. The same command clears the elapsed-tick counter and restarts both the prescaler and the divisor phase. A divisor of zero stops the generator. A readback command copies the elapsed-tick count onto `reg_c`. An arming command with a nonzero argument turns on tick interrupts and stores the argument as the message word; a zero argument turns them off. Constant identifier and version outputs let a host enumerate the device.

The tick generator runs a two-state machine. RUN_STOPPED moves to RUN_ACTIVE on a period command with nonzero B, and RUN_ACTIVE moves back to RUN_STOPPED on a period command with B = 0. The interrupt unit runs a three-state machine. IRQ_OFF moves to IRQ_ARMED on an arming command with nonzero B. IRQ_ARMED moves to IRQ_WAIT on a tick, which is also when it emits a pulse. IRQ_WAIT moves to IRQ_ARMED on `irq_ack`. Any state goes to IRQ_OFF on an arming command with B = 0, and any state goes to IRQ_ARMED on an arming command with nonzero B.

Top module: `tick_timer`

## Requirements
- R1: A command with `reg_a` = 0 and `reg_b` = B ≠ 0 makes the block tick once every B × `CLK_PER_BASE` clock cycles. Counting from the command edge e0, the elapsed count becomes m at edge e0 + m·B·`CLK_PER_BASE`.
- R2: A command with `reg_a` = 0 and `reg_b` = 0 stops ticking. The elapsed count then stays at 0.
- R3: A command with `reg_a` = 1, sampled at edge e1, loads `reg_c` with the elapsed count held just before e1. That count is floor((e1 − e0 − 1) / (B·`CLK_PER_BASE`)). `reg_c` changes at no other time.
- R4: Every `reg_a` = 0 command clears the elapsed count and restarts the prescaler and divisor phase from zero.
- R5: The elapsed count is 16 bits wide. It wraps to 0 after 65535, and it only ever holds, increments by one, or clears.
- R6: A command with `reg_a` = 2 and `reg_b` ≠ 0 arms interrupts and stores `reg_b` on `irq_msg`. While armed, each tick gives a `irq_pulse` exactly one cycle wide. `irq_msg` changes only on such an arming command.
- R7: A command with `reg_a` = 2 and `reg_b` = 0 disarms interrupts. From the second cycle after that command onward there are no pulses, and `irq_msg` keeps its value.
- R8: After a pulse, further ticks are dropped until `irq_ack` is high for a cycle. The next tick after that produces a pulse again.
- R9: Commands with any `reg_a` value other than 0, 1 or 2 leave `reg_c`, the tick period and the interrupt setup unchanged.
- R10: `hw_id` is always 32'h12d0b402 and `hw_version` is always 1.
- R11: While in reset, `reg_c` is 0, `irq_pulse` is 0 and `irq_msg` is 0. The generator is stopped and interrupts are disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| reg_a | input | 16 | Operation select |
| reg_b | input | 16 | Command argument |
| reg_c | output | 16 | Result word (elapsed tick count) |
| irq_ack | input | 1 | Host acknowledge of the last interrupt |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_msg | output | 16 | Message carried by the interrupt |
| hw_id | output | 32 | Hardware identifier |
| hw_version | output | 16 | Hardware version |

## Verification
A table of period commands runs divisors 1, 2, 4 and 7, plus the stopped case, with read delays placed one cycle before and exactly on a tick boundary. This separates off-by-one errors in the prescaler, the divisor and the readback sampling. A double period command issued mid-period shows whether the phase really restarts. An out-of-range opcode placed between two readbacks shows whether it disturbs `reg_c` or the running period. Interrupt windows are run with no acknowledge, a single acknowledge, acknowledge held high, and after disarming; these tell dropping apart from queuing and from a missing disarm. A second instance with a one-cycle base period ticks on every clock, which pushes the counter across its 16-bit wrap.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        OP_PERIOD = 2'd0,
        OP_READ   = 2'd1,
        OP_IRQ    = 2'd2
    } tt_op_e;

    typedef enum logic {
        RUN_STOPPED = 1'b0,
        RUN_ACTIVE  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_WAIT  = 2'd2
    } irq_state_e;

    localparam logic [31:0] TT_HW_ID  = 32'h12d0_b402;
    localparam logic [15:0] TT_HW_VER = 16'd1;
endpackage

// File: rtl/tt_cmd_decode.sv
module tt_cmd_decode #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] op,
    output logic              do_period,
    output logic              do_read,
    output logic              do_irq
);
    import tt_pkg::*;

    always_comb begin
        do_period = cmd_valid && (op == WORD_W'(OP_PERIOD));
        do_read   = cmd_valid && (op == WORD_W'(OP_READ));
        do_irq    = cmd_valid && (op == WORD_W'(OP_IRQ));
    end
endmodule

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
    parameter int unsigned CLK_PER_BASE = 833333,
    parameter int unsigned DIV_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] new_div,
    output logic             tick
);
    import tt_pkg::*;

    localparam int unsigned PW = (CLK_PER_BASE > 1) ? $clog2(CLK_PER_BASE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_BASE - 1);

    run_state_e       state_q, state_d;
    logic [PW-1:0]    pre_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] per_q;
    logic             base_last;
    logic             period_last;

    assign base_last   = (pre_q == PRE_LAST);
    assign period_last = (div_q == per_q - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_STOPPED: if (restart && new_div != '0) state_d = RUN_ACTIVE;
            RUN_ACTIVE:  if (restart && new_div == '0) state_d = RUN_STOPPED;
            default:     state_d = RUN_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_STOPPED;
        else        state_q <= state_d;
    end

    // prescaler and divisor counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
            per_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            div_q <= '0;
            per_q <= new_div;
        end else if (state_q == RUN_ACTIVE) begin
            if (base_last) begin
                pre_q <= '0;
                div_q <= period_last ? '0 : div_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tick = (state_q == RUN_ACTIVE) && base_last && period_last && !restart;
    end
endmodule

// File: rtl/tt_irq_ctrl.sv
module tt_irq_ctrl #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_cmd,
    input  logic [WORD_W-1:0] arm_msg,
    input  logic              tick,
    input  logic              ack,
    output logic              irq_pulse,
    output logic [WORD_W-1:0] irq_msg
);
    import tt_pkg::*;

    irq_state_e state_q, state_d;
    logic       fire;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (arm_cmd) begin
            state_d = (arm_msg != '0) ? IRQ_ARMED : IRQ_OFF;
        end else begin
            unique case (state_q)
                IRQ_OFF:   state_d = IRQ_OFF;
                IRQ_ARMED: if (tick) state_d = IRQ_WAIT;
                IRQ_WAIT:  if (ack)  state_d = IRQ_ARMED;
                default:   state_d = IRQ_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_OFF;
        else        state_q <= state_d;
    end

    assign fire = (state_q == IRQ_ARMED) && tick && !arm_cmd;

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_msg   <= '0;
        end else begin
            irq_pulse <= fire;
            if (arm_cmd && arm_msg != '0) irq_msg <= arm_msg;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned CLK_PER_BASE = 833333,
    parameter int unsigned WORD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] reg_a,
    input  logic [WORD_W-1:0] reg_b,
    output logic [WORD_W-1:0] reg_c,
    input  logic              irq_ack,
    output logic              irq_pulse,
    output logic [WORD_W-1:0] irq_msg,
    output logic [31:0]       hw_id,
    output logic [15:0]       hw_version
);
    import tt_pkg::*;

    logic              do_period;
    logic              do_read;
    logic              do_irq;
    logic              tick_w;
    logic [WORD_W-1:0] elapsed_q;

    tt_cmd_decode #(.WORD_W(WORD_W)) u_dec (
        .cmd_valid (cmd_valid),
        .op        (reg_a),
        .do_period (do_period),
        .do_read   (do_read),
        .do_irq    (do_irq)
    );

    tt_tick_gen #(.CLK_PER_BASE(CLK_PER_BASE), .DIV_W(WORD_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_period),
        .new_div (reg_b),
        .tick    (tick_w)
    );

    tt_irq_ctrl #(.WORD_W(WORD_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_cmd   (do_irq),
        .arm_msg   (reg_b),
        .tick      (tick_w),
        .ack       (irq_ack),
        .irq_pulse (irq_pulse),
        .irq_msg   (irq_msg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         elapsed_q <= '0;
        else if (do_period) elapsed_q <= '0;
        else if (tick_w)    elapsed_q <= elapsed_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       reg_c <= '0;
        else if (do_read) reg_c <= elapsed_q;
    end

    assign hw_id      = TT_HW_ID;
    assign hw_version = TT_HW_VER;
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] reg_b,
    input logic [W-1:0] reg_c,
    input logic         irq_pulse,
    input logic [W-1:0] irq_msg,
    input logic [W-1:0] elapsed
);
    // R3
    reg_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && reg_a == W'(1)) |=> $stable(reg_c));

    // R6
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6
    irq_msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && reg_a == W'(2) && reg_b != '0) |=> $stable(irq_msg));

    // R7
    irq_disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && reg_a == W'(2) && reg_b == '0) |=> ##1 !irq_pulse);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed == $past(elapsed)) || (elapsed == $past(elapsed) + W'(1)) || (elapsed == '0));
endmodule

bind tick_timer tt_timer_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_c     (reg_c),
    .irq_pulse (irq_pulse),
    .irq_msg   (irq_msg),
    .elapsed   (elapsed_q)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    localparam int unsigned P0 = 3;
    localparam int unsigned NV = 8;
    // {divisor, wait edges, expected count} with base period P0
    localparam logic [47:0] VEC [NV] = '{
        {16'd1, 16'd2,   16'd0},
        {16'd1, 16'd3,   16'd1},
        {16'd1, 16'd10,  16'd3},
        {16'd2, 16'd5,   16'd0},
        {16'd2, 16'd6,   16'd1},
        {16'd4, 16'd30,  16'd2},
        {16'd0, 16'd30,  16'd0},
        {16'd7, 16'd100, 16'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] reg_a = '0;
    logic [15:0] reg_b = '0;
    logic        irq_ack = 1'b0;
    logic [15:0] c0, c1, msg0, msg1, ver0, ver1;
    logic        pulse0, pulse1;
    logic [31:0] id0, id1;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    logic [15:0] last_msg = '0;

    always #5 clk = ~clk;

    tick_timer #(.CLK_PER_BASE(P0)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .reg_a(reg_a), .reg_b(reg_b),
        .reg_c(c0), .irq_ack(irq_ack), .irq_pulse(pulse0), .irq_msg(msg0),
        .hw_id(id0), .hw_version(ver0)
    );

    tick_timer #(.CLK_PER_BASE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .reg_a(reg_a), .reg_b(reg_b),
        .reg_c(c1), .irq_ack(irq_ack), .irq_pulse(pulse1), .irq_msg(msg1),
        .hw_id(id1), .hw_version(ver1)
    );

    always @(negedge clk) begin
        if (rst_n && pulse0) begin
            irq_cnt  = irq_cnt + 1;
            last_msg = msg0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic [15:0] b);
        cmd_valid = 1'b1;
        reg_a = a;
        reg_b = b;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(190000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 reg_c", 32'(c0), 32'd0);
        check("R11 irq_pulse", 32'(pulse0), 32'd0);
        check("R11 irq_msg", 32'(msg0), 32'd0);
        // R10 identification
        check("R10 hw_id", id0, 32'h12d0b402);
        check("R10 hw_version", 32'(ver0), 32'd1);
        rst_n = 1'b1;
        wait_edges(2);
        // R2 stopped after reset: count stays 0
        wait_edges(10);
        issue(16'd1, 16'd0);
        check("R2 idle count", 32'(c0), 32'd0);

        // R1 R2 R3 table of period / readback vectors
        for (int i = 0; i < NV; i++) begin
            issue(16'd0, VEC[i][47:32]);
            wait_edges(int'(VEC[i][31:16]));
            issue(16'd1, 16'd0);
            check($sformatf("R1/R3 vec%0d", i), 32'(c0), 32'(VEC[i][15:0]));
        end

        // R4 phase restart: second period command mid-period
        issue(16'd0, 16'd2);
        wait_edges(4);
        issue(16'd0, 16'd2);
        wait_edges(5);
        issue(16'd1, 16'd0);
        check("R4 restart", 32'(c0), 32'd0);

        // R9 unknown opcode leaves reg_c and period alone
        issue(16'd0, 16'd1);
        wait_edges(5);
        issue(16'd1, 16'd0);
        check("R9 pre", 32'(c0), 32'd1);
        issue(16'd3, 16'd0);
        check("R9 reg_c held", 32'(c0), 32'd1);
        wait_edges(4);
        issue(16'd1, 16'd0);
        check("R9 period kept", 32'(c0), 32'd3);

        // R6 R8 interrupts, tick every 3 cycles
        issue(16'd0, 16'd1);
        issue(16'd2, 16'hBEEF);
        base = irq_cnt;
        wait_edges(30);
        check("R8 unacked drop", 32'(irq_cnt - base), 32'd1);
        check("R6 message", 32'(last_msg), 32'hBEEF);
        irq_ack = 1'b1;
        wait_edges(1);
        irq_ack = 1'b0;
        wait_edges(30);
        check("R8 after ack", 32'(irq_cnt - base), 32'd2);
        base = irq_cnt;
        irq_ack = 1'b1;
        wait_edges(30);
        irq_ack = 1'b0;
        check_range("R6 pulse per tick", irq_cnt - base, 9, 11);

        // R7 disarm
        issue(16'd2, 16'd0);
        wait_edges(1);
        base = irq_cnt;
        irq_ack = 1'b1;
        wait_edges(30);
        irq_ack = 1'b0;
        check("R7 no pulses", 32'(irq_cnt - base), 32'd0);
        check("R7 msg kept", 32'(msg0), 32'hBEEF);

        // R5 wrap on the one-cycle-base instance
        issue(16'd0, 16'd1);
        wait_edges(65537);
        issue(16'd1, 16'd0);
        check("R5 wrap", 32'(c1), 32'd1);
        check("R1 long run", 32'(c0), 32'd21845);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule